// File: doc/BRIEF.md
# Overlaid Multi-Width Register File

This block holds eight 32-bit general registers. Software-visible names of three widths all map onto this one store. A full-width name covers a whole register. A half-width name covers its lower 16 bits. Two byte-width names, a low one and a high one, exist only for the first four registers. Any name can be used for a write, and the write changes only the bits that the name covers. A read through any name returns those bits right-justified and zero-extended.

The block has one write port and two independent read ports. Every port selects a register by a 3-bit index and a view by a 2-bit code. Writes take effect at the rising clock edge. Reads are combinational from the stored state, so a read issued in the same cycle as a write to that register still returns the value from before the write. A byte view aimed at registers 4 to 7 is rejected. On the write port it raises an error flag and nothing is stored. On a read port it raises that port's error flag and the port returns zero.

Top module: `regview_regfile`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to zero.
- R2: The view code selects the bits as follows: 0 = bits 31:0, 1 = bits 15:0, 2 = bits 7:0, 3 = bits 15:8.
- R3: A write with view 0 replaces all 32 bits. The new value is then visible through every view of that register.
- R4: A write with view 1 stores wr_data[15:0] into bits 15:0 and leaves bits 31:16 unchanged.
- R5: A write with view 2 stores wr_data[7:0] into bits 7:0. A write with view 3 stores wr_data[7:0] into bits 15:8. Each leaves all other bits unchanged.
- R6: A write with view 2 or 3 to index 4 to 7 is illegal. wr_err is high in that cycle, and no register changes.
- R7: A read with view 2 or 3 at index 4 to 7 raises that port's error flag and returns zero.
- R8: Legal reads return the selected bits in the low bits of the result, with all higher bits zero.
- R9: A read of a register in the same cycle it is written returns the value held before the write.
- R10: A write changes only the indexed register. With wr_en low, no register changes.
- R11: The two read ports decode index and view independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register index for the write |
| wr_view | input | 2 | View code for the write |
| wr_data | input | 32 | Write value, right-justified |
| wr_err | output | 1 | Illegal write view/index pairing |
| rd0_idx | input | 3 | Register index, read port 0 |
| rd0_view | input | 2 | View code, read port 0 |
| rd0_data | output | 32 | Zero-extended read result, port 0 |
| rd0_err | output | 1 | Illegal read, port 0 |
| rd1_idx | input | 3 | Register index, read port 1 |
| rd1_view | input | 2 | View code, read port 1 |
| rd1_data | output | 32 | Zero-extended read result, port 1 |
| rd1_err | output | 1 | Illegal read, port 1 |

## Verification
A narrow write and a read of the same register can fall in the same cycle. The read must then see the value from before the merge, and the merge becomes visible only after the edge. The random stimulus aims read port 0 at the write index about half the time, with views chosen independently. Directed steps repeat this with byte writes. The bench compares each read, taken just after the falling edge, against a model that is updated only after the rising edge. Illegal byte requests are mixed in, to show that a rejected write leaves the old value readable in the following cycle.

// File: rtl/regview_pkg.sv
package regview_pkg;

    parameter int unsigned REG_COUNT      = 8;
    parameter int unsigned REG_W          = 32;
    parameter int unsigned HALF_W         = 16;
    parameter int unsigned BYTE_W         = 8;
    parameter int unsigned BYTE_REG_COUNT = 4;
    localparam int unsigned IDX_W         = $clog2(REG_COUNT);

    typedef enum logic [1:0] {
        VW_FULL = 2'd0,
        VW_HALF = 2'd1,
        VW_BLO  = 2'd2,
        VW_BHI  = 2'd3
    } view_e;

    typedef logic [REG_W-1:0] word_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        view_e view;
        word_t data;
    } wr_req_t;

    typedef struct packed {
        idx_t  idx;
        view_e view;
    } rd_req_t;

    function automatic logic is_byte_view(view_e v);
        return (v == VW_BLO) || (v == VW_BHI);
    endfunction

    function automatic logic view_legal(idx_t idx, view_e v);
        return !(is_byte_view(v) && (int'(idx) >= int'(BYTE_REG_COUNT)));
    endfunction

    function automatic word_t lane_mask(view_e v);
        word_t m;
        m = '0;
        unique case (v)
            VW_FULL: m = '1;
            VW_HALF: m[HALF_W-1:0] = '1;
            VW_BLO:  m[BYTE_W-1:0] = '1;
            VW_BHI:  m[2*BYTE_W-1:BYTE_W] = '1;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic word_t lane_align(word_t d, view_e v);
        word_t r;
        r = '0;
        unique case (v)
            VW_FULL: r = d;
            VW_HALF: r[HALF_W-1:0] = d[HALF_W-1:0];
            VW_BLO:  r[BYTE_W-1:0] = d[BYTE_W-1:0];
            VW_BHI:  r[2*BYTE_W-1:BYTE_W] = d[BYTE_W-1:0];
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic word_t lane_extract(word_t w, view_e v);
        word_t r;
        r = '0;
        unique case (v)
            VW_FULL: r = w;
            VW_HALF: r[HALF_W-1:0] = w[HALF_W-1:0];
            VW_BLO:  r[BYTE_W-1:0] = w[BYTE_W-1:0];
            VW_BHI:  r[BYTE_W-1:0] = w[2*BYTE_W-1:BYTE_W];
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/regview_wr_decode.sv
module regview_wr_decode
    import regview_pkg::*;
#(
    parameter int unsigned NREGS = REG_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           req,
    output logic [NREGS-1:0]  wen,
    output word_t             wmask,
    output word_t             wval,
    output logic              err
);

    logic legal;

    always_comb begin
        legal = view_legal(req.idx, req.view);
        err   = req.en && !legal;
        wmask = lane_mask(req.view);
        wval  = lane_align(req.data, req.view);
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_wen
        assign wen[g] = req.en && legal && (int'(req.idx) == g);
    end

    // R10
    wen_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wen));

    // R6
    err_blocks_wen_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (wen == '0));

endmodule

// File: rtl/regview_bank.sv
module regview_bank
    import regview_pkg::*;
#(
    parameter int unsigned NREGS = REG_COUNT,
    parameter int unsigned WIDTH = REG_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NREGS-1:0]             wen,
    input  logic [WIDTH-1:0]             wmask,
    input  logic [WIDTH-1:0]             wval,
    output logic [NREGS-1:0][WIDTH-1:0]  regs_q
);

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (wen[g]) begin
                regs_q[g] <= (regs_q[g] & ~wmask) | (wval & wmask);
            end
        end

        // R10
        idle_reg_stable_chk: assert property (@(posedge clk) disable iff (rst)
            !wen[g] |=> $stable(regs_q[g]));

        // R4
        masked_bits_kept_chk: assert property (@(posedge clk) disable iff (rst)
            wen[g] |=> ((regs_q[g] & ~$past(wmask)) == ($past(regs_q[g]) & ~$past(wmask))));
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (regs_q == '0));

endmodule

// File: rtl/regview_rd_port.sv
module regview_rd_port
    import regview_pkg::*;
#(
    parameter int unsigned NREGS = REG_COUNT
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NREGS-1:0][REG_W-1:0]  regs_q,
    input  rd_req_t                      req,
    output word_t                        data,
    output logic                         err
);

    word_t picked;

    always_comb begin
        picked = regs_q[req.idx];
        err    = !view_legal(req.idx, req.view);
        data   = err ? '0 : lane_extract(picked, req.view);
    end

    // R7
    illegal_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (data == '0));

    // R8
    narrow_read_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (req.view != VW_FULL) |-> (data[REG_W-1:HALF_W] == '0));

endmodule

// File: rtl/regview_regfile.sv
module regview_regfile
    import regview_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_idx,
    input  logic [1:0]  wr_view,
    input  logic [31:0] wr_data,
    output logic        wr_err,
    input  logic [2:0]  rd0_idx,
    input  logic [1:0]  rd0_view,
    output logic [31:0] rd0_data,
    output logic        rd0_err,
    input  logic [2:0]  rd1_idx,
    input  logic [1:0]  rd1_view,
    output logic [31:0] rd1_data,
    output logic        rd1_err
);

    localparam int unsigned NPORTS = 2;

    wr_req_t                        wreq;
    rd_req_t [NPORTS-1:0]           rreq;
    word_t   [NPORTS-1:0]           rdata;
    logic    [NPORTS-1:0]           rerr;
    logic    [REG_COUNT-1:0]        wen;
    word_t                          wmask;
    word_t                          wval;
    logic [REG_COUNT-1:0][REG_W-1:0] regs_q;

    always_comb begin
        wreq.en   = wr_en;
        wreq.idx  = wr_idx;
        wreq.view = view_e'(wr_view);
        wreq.data = wr_data;
        rreq[0].idx  = rd0_idx;
        rreq[0].view = view_e'(rd0_view);
        rreq[1].idx  = rd1_idx;
        rreq[1].view = view_e'(rd1_view);
    end

    regview_wr_decode #(.NREGS(REG_COUNT)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .req   (wreq),
        .wen   (wen),
        .wmask (wmask),
        .wval  (wval),
        .err   (wr_err)
    );

    regview_bank #(.NREGS(REG_COUNT), .WIDTH(REG_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wen    (wen),
        .wmask  (wmask),
        .wval   (wval),
        .regs_q (regs_q)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        regview_rd_port #(.NREGS(REG_COUNT)) u_rd (
            .clk    (clk),
            .rst    (rst),
            .regs_q (regs_q),
            .req    (rreq[p]),
            .data   (rdata[p]),
            .err    (rerr[p])
        );
    end

    assign rd0_data = rdata[0];
    assign rd0_err  = rerr[0];
    assign rd1_data = rdata[1];
    assign rd1_err  = rerr[1];

    // R6
    rejected_write_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> $stable(regs_q));

    // R10
    no_write_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q));

    // R9
    read_sees_old_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (rd0_idx == wr_idx) && (rd0_view == 2'd0)) |-> (rd0_data == regs_q[rd0_idx]));

endmodule

// File: tb/regview_regfile_tb_top.sv
`timescale 1ns/1ps
module regview_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_view = '0;
    logic [31:0] wr_data = '0;
    logic        wr_err;
    logic [2:0]  rd0_idx = '0;
    logic [1:0]  rd0_view = '0;
    logic [31:0] rd0_data;
    logic        rd0_err;
    logic [2:0]  rd1_idx = '0;
    logic [1:0]  rd1_view = '0;
    logic [31:0] rd1_data;
    logic        rd1_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] model [8];

    always #2.5 clk = ~clk;

    regview_regfile dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data), .wr_err(wr_err),
        .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_data(rd1_data), .rd1_err(rd1_err)
    );

    function automatic bit m_legal(int idx, int v);
        return !((v >= 2) && (idx >= 4));
    endfunction

    function automatic logic [31:0] m_read(int idx, int v);
        logic [31:0] w;
        w = model[idx];
        if (!m_legal(idx, v)) return 32'h0;
        case (v)
            0: return w;
            1: return {16'h0, w[15:0]};
            2: return {24'h0, w[7:0]};
            default: return {24'h0, w[15:8]};
        endcase
    endfunction

    function automatic logic [31:0] m_merge(logic [31:0] old, logic [31:0] d, int v);
        case (v)
            0: return d;
            1: return {old[31:16], d[15:0]};
            2: return {old[31:8], d[7:0]};
            default: return {old[31:16], d[7:0], old[7:0]};
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, bit we, int wi, int wv, logic [31:0] wd,
                        int r0i, int r0v, int r1i, int r1v);
        @(negedge clk);
        wr_en = we; wr_idx = 3'(wi); wr_view = 2'(wv); wr_data = wd;
        rd0_idx = 3'(r0i); rd0_view = 2'(r0v);
        rd1_idx = 3'(r1i); rd1_view = 2'(r1v);
        #1;
        check({tag, " rd0"}, rd0_data, m_read(r0i, r0v));
        check({tag, " rd0_err"}, 32'(rd0_err), 32'(!m_legal(r0i, r0v)));
        check({tag, " rd1"}, rd1_data, m_read(r1i, r1v));
        check({tag, " rd1_err"}, 32'(rd1_err), 32'(!m_legal(r1i, r1v)));
        check({tag, " wr_err"}, 32'(wr_err), 32'(we && !m_legal(wi, wv)));
        @(posedge clk);
        if (we && m_legal(wi, wv)) model[wi] = m_merge(model[wi], wd, wv);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) model[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int i = 0; i < 8; i++) step("R1 reset", 0, 0, 0, 0, i, 0, i, 1);
        // R3 full write, seen through all views (R2)
        step("R3 wr", 1, 0, 0, 32'h1122_3344, 0, 0, 0, 0);
        step("R2 views", 0, 0, 0, 0, 0, 1, 0, 2);
        step("R2 hi", 0, 0, 0, 0, 0, 3, 0, 0);
        // R5 high byte merge, R9 read old in write cycle
        step("R9 bhi", 1, 0, 3, 32'hFFFF_FFAB, 0, 0, 0, 3);
        step("R5 after", 0, 0, 0, 0, 0, 0, 0, 3);
        step("R5 blo", 1, 0, 2, 32'hDEAD_BE5A, 0, 2, 0, 0);
        // R4 half merge
        step("R4 half", 1, 0, 1, 32'hCAFE_0F0F, 0, 0, 1, 0);
        step("R4 after", 0, 0, 0, 0, 0, 0, 0, 1);
        // R6 illegal writes, R7 illegal reads
        step("R6 setup", 1, 5, 0, 32'hA5A5_5A5A, 5, 0, 5, 1);
        step("R6 bhi", 1, 5, 3, 32'h0000_00EE, 5, 3, 5, 0);
        step("R6 blo", 1, 6, 2, 32'h0000_00EE, 6, 2, 5, 0);
        step("R7 after", 0, 0, 0, 0, 5, 2, 5, 0);
        // R10 wr_en low and other registers untouched
        step("R10 idle", 0, 1, 0, 32'hFFFF_FFFF, 1, 0, 0, 0);
        step("R10 iso", 1, 3, 0, 32'h7777_7777, 2, 0, 4, 0);
        // R11 independent ports, R8 zero extension
        step("R11 ports", 0, 0, 0, 0, 3, 2, 0, 3);
        step("R8 zext", 0, 0, 0, 0, 3, 1, 5, 1);
        // random mix
        for (int n = 0; n < 4000; n++) begin
            int wi, wv, r0i, r0v, r1i, r1v;
            bit we;
            we  = ($urandom % 4) != 0;
            wi  = $urandom % 8;
            wv  = $urandom % 4;
            r0i = ($urandom % 2) ? wi : ($urandom % 8);
            r0v = $urandom % 4;
            r1i = $urandom % 8;
            r1v = $urandom % 4;
            step("R9 rand", we, wi, wv, $urandom, r0i, r0v, r1i, r1v);
        end
        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 8; i++) model[i] = 32'h0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) step("R1 rerst", 0, 0, 0, 0, i, 0, i, 0);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule